// File: doc/BRIEF.md
# Triggered Burst Resolution Controller

This block decides, sample by sample, whether a converter's output stream is at low resolution or at full resolution. When burst operation is switched on, it first forces a long low-resolution lockout. It then raises a ready flag and waits for a fresh rising edge on a trigger line. Each accepted trigger opens a full-resolution burst whose length is a programmable power of two. A second, longer low-resolution lockout follows, and then the block re-arms.

The burst exponent is a small register value. It is captured when a burst starts, which fixes the burst length. It is captured again on the final burst sample, which fixes the following lockout length. Trigger activity outside the armed state is discarded. Dropping the enable returns the block to plain low-resolution operation at once.

Top module: `burst_res_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `arm_rdy`, `hires_flag` and `hires_sel` are all 0.
- R2: When `burst_en` is sampled high from the idle state, exactly 2^13 low-resolution cycles follow. `arm_rdy` then reads 1 on the 8193rd cycle after that edge.
- R3: A trigger that changes during a lockout is ignored. The lockout length is unchanged and no burst starts. A trigger that is already high when the block arms does not start a burst until it has gone low and risen again.
- R4: When the block is armed and `trig_in` is sampled at 1 on an edge after being sampled at 0 on the previous edge, `hires_flag` is 1 and `arm_rdy` is 0 from the next cycle on.
- R5: A burst lasts exactly 2^N cycles. N is the `burst_exp` value sampled on the edge that accepts the trigger.
- R6: A `burst_exp` value above 10 is treated as 10.
- R7: The lockout after a burst lasts exactly 2^(N+3) cycles, with N re-sampled (and limited to 10) on the last burst edge. `arm_rdy` returns to 1 on the cycle after the lockout.
- R8: `hires_sel` equals `hires_flag` on every cycle.
- R9: `burst_en` sampled low makes all three outputs 0 from the next cycle on. Enabling again restarts the 2^13-cycle initial lockout.
- R10: `arm_rdy` and `hires_flag` are never 1 on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| burst_en | input | 1 | Enables burst sequencing; low means continuous low resolution |
| trig_in | input | 1 | Burst trigger; only a fresh rising edge is accepted |
| burst_exp | input | 4 | Burst exponent N (burst of 2^N, lockout of 2^(N+3)) |
| hires_sel | output | 1 | Resolution select to the output data path, 1 = full resolution |
| arm_rdy | output | 1 | High while a trigger can be accepted |
| hires_flag | output | 1 | High on every full-resolution sample |

## Verification
A wrong phase code or a misloaded counter shows as a burst or lockout window of the wrong length. This appears at the ports on the cycle where `hires_flag` or `arm_rdy` should change, which is at most 2^13 cycles after the fault. A stale edge-detector bit shows as a burst started by a held trigger, or as a missed burst on a clean edge, on the first armed cycle. A fault in the exponent capture changes the next window's length by a power of two. A reference model that checks every cycle catches each of these on the first wrong sample.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INIT  = 3'd1,
    PH_ARMED = 3'd2,
    PH_BURST = 3'd3,
    PH_POST  = 3'd4
  } phase_t;
endpackage

// File: rtl/brc_rise_det.sv
module brc_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= din;
  end

  // A rise is a 1 on this edge after a 0 was seen on the previous one.
  assign rise = din & ~din_q;
endmodule

// File: rtl/brc_len_dec.sv
module brc_len_dec #(
  parameter int EXP_W   = 4,
  parameter int EXP_MAX = 10,
  parameter int EXTRA   = 3,
  parameter int CW      = 14
) (
  input  logic [EXP_W-1:0] exp_in,
  output logic [CW-1:0]    burst_m1,
  output logic [CW-1:0]    lock_m1
);
  logic [EXP_W-1:0] n_eff;

  always_comb begin
    if (exp_in > EXP_W'(EXP_MAX)) n_eff = EXP_W'(EXP_MAX);
    else                          n_eff = exp_in;
    burst_m1 = (CW'(1) << n_eff) - CW'(1);
    lock_m1  = (CW'(1) << (n_eff + EXP_W'(EXTRA))) - CW'(1);
  end
endmodule

// File: rtl/brc_down_cnt.sv
module brc_down_cnt #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/burst_res_ctrl.sv
module burst_res_ctrl #(
  parameter int EXP_W     = 4,
  parameter int EXP_MAX   = 10,
  parameter int LOCK_XTRA = 3,
  parameter int INIT_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             burst_en,
  input  logic             trig_in,
  input  logic [EXP_W-1:0] burst_exp,
  output logic             hires_sel,
  output logic             arm_rdy,
  output logic             hires_flag
);
  import brc_pkg::*;

  localparam int MAX_LOG2 = (INIT_LOG2 > EXP_MAX + LOCK_XTRA) ? INIT_LOG2 : EXP_MAX + LOCK_XTRA;
  localparam int CW       = MAX_LOG2 + 1;
  localparam logic [CW-1:0] INIT_M1 = (CW'(1) << INIT_LOG2) - CW'(1);

  phase_t        ph, ph_nxt;
  logic          trig_rise;
  logic          cnt_zero;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic [CW-1:0] burst_m1, lock_m1;

  brc_rise_det u_rise (
    .clk  (clk),
    .rst  (rst),
    .din  (trig_in),
    .rise (trig_rise)
  );

  brc_len_dec #(
    .EXP_W   (EXP_W),
    .EXP_MAX (EXP_MAX),
    .EXTRA   (LOCK_XTRA),
    .CW      (CW)
  ) u_len (
    .exp_in   (burst_exp),
    .burst_m1 (burst_m1),
    .lock_m1  (lock_m1)
  );

  brc_down_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  always_comb begin
    ph_nxt   = ph;
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (!burst_en) begin
      ph_nxt = PH_IDLE;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          ph_nxt   = PH_INIT;
          cnt_load = 1'b1;
          cnt_val  = INIT_M1;
        end
        PH_INIT:  if (cnt_zero) ph_nxt = PH_ARMED;
        PH_ARMED: if (trig_rise) begin
          ph_nxt   = PH_BURST;
          cnt_load = 1'b1;
          cnt_val  = burst_m1;
        end
        PH_BURST: if (cnt_zero) begin
          ph_nxt   = PH_POST;
          cnt_load = 1'b1;
          cnt_val  = lock_m1;
        end
        PH_POST:  if (cnt_zero) ph_nxt = PH_ARMED;
        default:  ph_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      arm_rdy    <= 1'b0;
      hires_flag <= 1'b0;
      hires_sel  <= 1'b0;
    end else begin
      ph         <= ph_nxt;
      arm_rdy    <= (ph_nxt == PH_ARMED);
      hires_flag <= (ph_nxt == PH_BURST);
      hires_sel  <= (ph_nxt == PH_BURST);
    end
  end

  // R10
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(arm_rdy && hires_flag));

  // R8
  sel_match_chk: assert property (@(posedge clk) disable iff (rst)
    hires_sel == hires_flag);

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !burst_en |=> (!arm_rdy && !hires_flag && !hires_sel));

  // R4
  burst_from_armed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hires_flag) |-> $past(arm_rdy));

  // R3
  lock_no_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_INIT || ph == PH_POST) |=> !hires_flag);

  // R4
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_en && arm_rdy && trig_rise) |=> (hires_flag && !arm_rdy));
endmodule

// File: tb/test_burst_res_ctrl.sv
module test_burst_res_ctrl;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       burst_en = 1'b0;
  logic       trig_in = 1'b0;
  logic [3:0] burst_exp = 4'd0;
  logic       hires_sel, arm_rdy, hires_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  // reference model state
  int m_ph = 0;      // 0 idle,1 init,2 armed,3 burst,4 post
  int m_left = 0;
  bit m_trq = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  burst_res_ctrl i_burst_res_ctrl (
    .clk        (clk),
    .rst        (rst),
    .burst_en   (burst_en),
    .trig_in    (trig_in),
    .burst_exp  (burst_exp),
    .hires_sel  (hires_sel),
    .arm_rdy    (arm_rdy),
    .hires_flag (hires_flag)
  );

  function automatic int lim_n(input logic [3:0] e);
    return (e > 4'd10) ? 10 : int'(e);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0; m_trq <= 1'b0; m_left <= 0;
    end else begin
      m_trq <= trig_in;
      if (!burst_en) m_ph <= 0;
      else case (m_ph)
        0: begin m_ph <= 1; m_left <= 8192; end
        1, 4: if (m_left == 1) m_ph <= 2; else m_left <= m_left - 1;
        2: if (trig_in && !m_trq) begin m_ph <= 3; m_left <= 1 << lim_n(burst_exp); end
        3: if (m_left == 1) begin m_ph <= 4; m_left <= 1 << (lim_n(burst_exp) + 3); end
           else m_left <= m_left - 1;
        default: m_ph <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      string r;
      case (m_ph)
        0: r = "R9";
        1: r = "R2";
        2: r = "R4";
        3: r = "R5";
        default: r = "R7";
      endcase
      check({r, " rdy"},   int'(arm_rdy),    int'(m_ph == 2));
      check({r, " hires"}, int'(hires_flag), int'(m_ph == 3));
      check("R8 sel",      int'(hires_sel),  int'(hires_flag));
      check("R10 excl",    int'(arm_rdy && hires_flag), 0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdy in reset", int'(arm_rdy), 0);
    check("R1 hires in reset", int'(hires_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sel after reset", int'(hires_sel), 0);
    model_on = 1'b1;

    // R2 initial lockout length
    burst_en = 1'b1; trig_in = 1'b1;   // held high: must not fire on arming (R3)
    n = 0;
    do begin @(negedge clk); n++; end while (!arm_rdy && n < 20000);
    check("R2 init lockout cycles", n, 8193);
    repeat (5) @(negedge clk);
    check("R3 held trigger no burst", int'(hires_flag), 0);
    trig_in = 1'b0;
    @(negedge clk);

    // R4 / R5 burst of 2^2, exponent changed mid-burst
    trig_in = 1'b1; burst_exp = 4'd2;
    @(negedge clk);
    check("R4 hires after edge", int'(hires_flag), 1);
    check("R4 rdy dropped", int'(arm_rdy), 0);
    n = 0;
    while (hires_flag && n < 5000) begin
      n++;
      if (n == 2) begin burst_exp = 4'd3; trig_in = 1'b0; end
      @(negedge clk);
    end
    check("R5 burst len N=2", n, 4);

    // R7 lockout 2^(3+3) with trigger toggling (R3)
    n = 0;
    while (!arm_rdy && n < 20000) begin
      n++;
      trig_in = ~trig_in;
      @(negedge clk);
    end
    check("R7 lockout len N=3", n, 64);
    check("R3 no burst in lockout", int'(hires_flag), 0);
    trig_in = 1'b0;
    @(negedge clk);

    // R6 exponent above 10
    trig_in = 1'b1; burst_exp = 4'd15;
    @(negedge clk);
    n = 0;
    while (hires_flag && n < 5000) begin n++; @(negedge clk); end
    check("R6 burst len clamp", n, 1024);

    // R9 disable in lockout then re-enable
    repeat (100) @(negedge clk);
    burst_en = 1'b0;
    @(negedge clk);
    check("R9 rdy off", int'(arm_rdy), 0);
    check("R9 hires off", int'(hires_flag), 0);
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    burst_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!arm_rdy && n < 20000);
    check("R9 restart init lockout", n, 8193);

    // random phase
    for (int i = 0; i < 50000; i++) begin
      if ($urandom % 6 == 0) trig_in = ~trig_in;
      if ($urandom % 400 == 0) burst_exp = 4'($urandom % 16);
      if ($urandom % 15000 == 0) burst_en = 1'b0;
      else burst_en = 1'b1;
      @(negedge clk);
    end
    finish_run();
  end
endmodule